// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer with Watchdog

This block is a 16-bit down-counting timer for a system bus. Software programs it through three word registers: a reload value, a control word and a status word. The control word carries an enable, a two-bit mode and a four-bit clock-divide select. A divider turns the input clock into count ticks, and the counter falls by one on each tick. Whenever a tick arrives while the count is already zero, the counter takes the action of its mode.

The four modes share one counter:
- **Free-running:** the count wraps to all ones.
- **Periodic:** the count reloads from the reload register.
- **One-shot:** the count parks at zero.
- **Watchdog:** the block issues a system reset request.

The first three modes set a sticky interrupt flag. Writing the reload register restarts the count at once. In watchdog mode that write is the keep-alive.

The watchdog records that it fired in a cause flag. A system reset does not clear that flag. Only a power-on reset or a write of one clears it, so software can read it after the reboot. The usual start sequence is: program mode and divider with enable low, write the reload value, then set enable.

Top module: `wdt_timer`

## Requirements
- R1: After power-on reset every register reads zero, the timer is disabled, and `irq` and `rst_req` are low.
- R2: Register map (byte offsets).
  - Offset 0x0: reload register. A write stores bits 15:0. A read returns the live count in bits 15:0, so 0xFFFF is accepted and read back.
  - Offset 0x4: status register. Bit 0 is the interrupt flag and bit 1 is the watchdog-cause flag. A write of 1 to either bit clears it.
  - Offset 0x8: control register. Bit 7 is enable. Bits 5:4 are the mode: 0 free-running, 1 periodic, 2 one-shot, 3 watchdog. Bits 3:0 are the divide select.
  - Control bit 6, and any other offset, read as zero.
- R3: A divide select of n produces one count tick every 2^(n+1) clocks. The first tick comes 2^(n+1) clocks after the enable rises or the reload register is written.
- R4: The count falls by one per tick while enabled. While enable is low the count holds.
- R5: A reload write loads the count in the same clock and restarts the divider, in every mode. In watchdog mode this write is the keep-alive.
- R6: A tick that arrives while the count is zero is an expiry. In free-running mode the count wraps to 0xFFFF and the interrupt flag is set.
- R7: In periodic mode an expiry reloads the count from the reload register and sets the interrupt flag.
- R8: In one-shot mode an expiry leaves the count at zero. It sets the interrupt flag only once until the next reload write or enable rise.
- R9: In watchdog mode an expiry raises `rst_req` for exactly one clock and sets the cause flag, but not the interrupt flag. There is at most one request per reload.
- R10: The cause flag survives `sys_rst_n`, which clears everything else. It is cleared by a write of 1 to status bit 1 or by `por_n`.
- R11: `irq` follows the sticky interrupt flag, which stays set until software writes 1 to status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| sys_rst_n | input | 1 | System reset, active low, spares the cause flag |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt flag |
| rst_req | output | 1 | One-clock system reset request |

## Verification
The bench targets the expiry-cycle position, which is one tick after the count reaches zero. An off-by-one counter would move every interrupt and reset event by a tick, and the event scoreboard flags that exact cycle.

A reload written part-way through a tick period must restart the divider. A design that skipped this would decrement early, and a read just before the expected tick catches it. The watchdog kick arrives one clock before the unkicked expiry, so a reload that failed to restart the count would fire a premature reset.

The cause flag is checked across a system reset and then across a power-on reset. One-shot and watchdog expiries are checked for repeat firing after the first event.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int PSEL_W = 4;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'd0,
        MODE_PERIODIC = 2'd1,
        MODE_ONESHOT  = 2'd2,
        MODE_WDOG     = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic              en;
        tmr_mode_e         mode;
        logic [PSEL_W-1:0] psel;
    } tmr_ctrl_t;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int SEL_W = PSEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int DIV_W = 2 ** SEL_W;

    typedef struct packed {
        logic [DIV_W-1:0] pre;
    } pre_state_t;

    pre_state_t       s_d, s_q;
    logic [DIV_W-1:0] term;

    always_comb begin
        term = {DIV_W{1'b1}} >> (SEL_W'(DIV_W - 1) - sel);
        tick = run && (s_q.pre == term);
        s_d  = s_q;
        if (clear || tick) begin
            s_d.pre = '0;
        end else if (run) begin
            s_d.pre = s_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R3: the smallest division is two, so ticks never come back to back
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  tmr_mode_e        mode,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             restart,
    output logic [CNT_W-1:0] count,
    output logic             evt_irq,
    output logic             evt_rst
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        evt_irq = 1'b0;
        evt_rst = 1'b0;
        if (load_wr) begin
            s_d.cnt  = load_val;
            s_d.done = 1'b0;
        end else begin
            if (restart) begin
                s_d.done = 1'b0;
            end
            if (tick) begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else begin
                    case (mode)
                        MODE_FREE: begin
                            s_d.cnt = '1;
                            evt_irq = 1'b1;
                        end
                        MODE_PERIODIC: begin
                            s_d.cnt = reload_val;
                            evt_irq = 1'b1;
                        end
                        MODE_ONESHOT: begin
                            if (!s_q.done) begin
                                s_d.done = 1'b1;
                                evt_irq  = 1'b1;
                            end
                        end
                        default: begin
                            if (!s_q.done) begin
                                s_d.done = 1'b1;
                                evt_rst  = 1'b1;
                            end
                        end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count = s_q.cnt;

    // R8: a one-shot count at zero stays there until software reloads it
    a_r8_oneshot_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ONESHOT && s_q.cnt == '0 && !load_wr) |=> (s_q.cnt == '0));

endmodule

// File: rtl/wdt_cause.sv
module wdt_cause (
    input  logic clk,
    input  logic por_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    typedef struct packed {
        logic hit;
    } cause_state_t;

    cause_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (set) begin
            s_d.hit = 1'b1;
        end else if (clr) begin
            s_d.hit = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flag = s_q.hit;

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              rst_req
);

    localparam logic [ADDR_W-1:0] OFS_LOAD = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(8);
    localparam int                EN_BIT   = 7;
    localparam int                MODE_LO  = 4;

    typedef struct packed {
        tmr_ctrl_t        ctrl;
        logic [CNT_W-1:0] load;
        logic             irq_flag;
        logic             rst_req;
    } regs_t;

    regs_t            r_d, r_q;
    logic             core_rst_n;
    logic             wr_load, wr_stat, wr_ctrl;
    logic             enable_rise;
    logic             tick;
    logic             evt_irq, evt_rst;
    logic             cause_flag;
    logic [CNT_W-1:0] count;
    logic             wdata_unused;

    assign core_rst_n   = por_n & sys_rst_n;
    assign wr_load      = bus_wr && (bus_addr == OFS_LOAD);
    assign wr_stat      = bus_wr && (bus_addr == OFS_STAT);
    assign wr_ctrl      = bus_wr && (bus_addr == OFS_CTRL);
    assign enable_rise  = wr_ctrl && bus_wdata[EN_BIT] && !r_q.ctrl.en;
    assign wdata_unused = ^{bus_wdata[DATA_W-1:CNT_W], bus_wdata[6]};

    always_comb begin
        r_d         = r_q;
        r_d.rst_req = evt_rst;
        if (wr_ctrl) begin
            r_d.ctrl.en   = bus_wdata[EN_BIT];
            r_d.ctrl.mode = tmr_mode_e'(bus_wdata[MODE_LO+1:MODE_LO]);
            r_d.ctrl.psel = bus_wdata[PSEL_W-1:0];
        end
        if (wr_load) begin
            r_d.load = bus_wdata[CNT_W-1:0];
        end
        if (evt_irq) begin
            r_d.irq_flag = 1'b1;
        end else if (wr_stat && bus_wdata[0]) begin
            r_d.irq_flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_LOAD: bus_rdata = DATA_W'(count);
            OFS_STAT: bus_rdata = DATA_W'({cause_flag, r_q.irq_flag});
            OFS_CTRL: bus_rdata = DATA_W'({r_q.ctrl.en, 1'b0, r_q.ctrl.mode, r_q.ctrl.psel});
            default:  bus_rdata = '0;
        endcase
    end

    assign irq     = r_q.irq_flag;
    assign rst_req = r_q.rst_req;

    wdt_prescaler #(
        .SEL_W (PSEL_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (core_rst_n),
        .run   (r_q.ctrl.en),
        .clear (wr_load || enable_rise),
        .sel   (r_q.ctrl.psel),
        .tick  (tick)
    );

    wdt_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (core_rst_n),
        .tick       (tick),
        .mode       (r_q.ctrl.mode),
        .load_wr    (wr_load),
        .load_val   (bus_wdata[CNT_W-1:0]),
        .reload_val (r_q.load),
        .restart    (enable_rise),
        .count      (count),
        .evt_irq    (evt_irq),
        .evt_rst    (evt_rst)
    );

    wdt_cause u_cause (
        .clk   (clk),
        .por_n (por_n),
        .set   (evt_rst),
        .clr   (wr_stat && bus_wdata[1]),
        .flag  (cause_flag)
    );

    // R9: the reset request never lasts longer than one clock
    a_r9_rst_one_clock: assert property (@(posedge clk) disable iff (!core_rst_n)
        rst_req |=> !rst_req);

    // R9: a reset request is always accompanied by the recorded cause
    a_r9_cause_with_rst: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |-> cause_flag);

    // R10: the cause flag only rises together with a watchdog firing
    a_r10_cause_source: assert property (@(posedge clk) disable iff (!por_n)
        $rose(cause_flag) |-> rst_req);

    // R9: watchdog expiry never raises the interrupt flag
    a_r9_no_irq_in_wdog: assert property (@(posedge clk) disable iff (!core_rst_n)
        $rose(r_q.irq_flag) |-> ($past(r_q.ctrl.mode) != MODE_WDOG));

    // R4: with the timer disabled and no reload, the count is frozen
    a_r4_hold_when_off: assert property (@(posedge clk) disable iff (!core_rst_n)
        (!r_q.ctrl.en && !wr_load) |=> $stable(count));

endmodule

// File: tb/wdt_timer_tb.sv
module wdt_timer_tb;

    localparam logic [3:0] A_LOAD = 4'h0;
    localparam logic [3:0] A_STAT = 4'h4;
    localparam logic [3:0] A_CTRL = 4'h8;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        rst_req;

    always #10 clk = ~clk;

    wdt_timer u_dut (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .rst_req   (rst_req)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        int at;
        int req;
    } evt_t;

    evt_t irq_q[$];
    evt_t rst_q[$];
    evt_t mon_e;
    logic irq_prev = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // monitor: pops the expected event cycle whenever an event is seen
    always @(negedge clk) begin
        if (por_n) begin
            if (rst_req) begin
                checks++;
                if (rst_q.size() == 0) begin
                    fails++;
                    $display("FAIL R9 rst_req actual=cycle %0d expected=none", cyc);
                end else begin
                    mon_e = rst_q.pop_front();
                    if (mon_e.at != cyc) begin
                        fails++;
                        $display("FAIL R%0d rst_req actual=cycle %0d expected=cycle %0d",
                                 mon_e.req, cyc, mon_e.at);
                    end
                end
            end
            if (irq && !irq_prev) begin
                checks++;
                if (irq_q.size() == 0) begin
                    fails++;
                    $display("FAIL R11 irq rise actual=cycle %0d expected=none", cyc);
                end else begin
                    mon_e = irq_q.pop_front();
                    if (mon_e.at != cyc) begin
                        fails++;
                        $display("FAIL R%0d irq rise actual=cycle %0d expected=cycle %0d",
                                 mon_e.req, cyc, mon_e.at);
                    end
                end
            end
        end
        irq_prev = irq;
    end

    task automatic push_irq(input int at, input int req);
        evt_t e;
        e.at = at;
        e.req = req;
        irq_q.push_back(e);
    endtask

    task automatic push_rst(input int at);
        evt_t e;
        e.at = at;
        e.req = 9;
        rst_q.push_back(e);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, output int e);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        e      = cyc;
        bus_wr = 1'b0;
    endtask

    task automatic wait_neg(input int t);
        do @(negedge clk); while (cyc < t);
    endtask

    task automatic rd_now(input logic [3:0] a, input logic [31:0] exp, input string req);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic rd_at(input logic [3:0] a, input int t, input logic [31:0] exp, input string req);
        wait_neg(t);
        rd_now(a, exp, req);
    endtask

    task automatic pulse_sys_rst();
        @(negedge clk);
        sys_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        sys_rst_n = 1'b1;
    endtask

    task automatic pulse_por();
        @(negedge clk);
        por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL hang actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int ee, ek, el, ew;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd_now(A_LOAD, 32'h0, "R1");
        rd_now(A_STAT, 32'h0, "R1");
        rd_now(A_CTRL, 32'h0, "R1");
        chk("R1", {30'b0, rst_req, irq}, 32'h0);

        // R2: register fields, bit 6 not stored, spare offset reads zero
        wr(A_CTRL, 32'h4F, ew);
        rd_at(A_CTRL, ew, 32'h0F, "R2");
        wr(A_LOAD, 32'h1234_FFFF, ew);
        rd_at(A_LOAD, ew, 32'hFFFF, "R2");
        rd_now(4'hC, 32'h0, "R2");

        // R8 one-shot, divide by 2, reload 3: expiry 8 clocks after enable
        wr(A_CTRL, 32'h20, ew);
        wr(A_LOAD, 32'd3, ew);
        wr(A_CTRL, 32'hA0, ee);
        push_irq(ee + 8, 8);
        rd_at(A_LOAD, ee + 2, 32'd2, "R4");
        rd_at(A_LOAD, ee + 6, 32'd0, "R4");
        wait_neg(ee + 8);
        chk("R11", {31'b0, irq}, 32'h1);
        rd_at(A_LOAD, ee + 12, 32'd0, "R8");
        rd_now(A_STAT, 32'h1, "R8");
        wr(A_STAT, 32'h1, ew);
        rd_at(A_STAT, ew, 32'h0, "R11");
        chk("R11", {31'b0, irq}, 32'h0);
        rd_at(A_STAT, ew + 20, 32'h0, "R8");
        wr(A_CTRL, 32'h20, ew);

        // R7 periodic, reload 2: period of 6 clocks
        wr(A_CTRL, 32'h10, ew);
        wr(A_LOAD, 32'd2, ew);
        wr(A_CTRL, 32'h90, ee);
        push_irq(ee + 6, 7);
        rd_at(A_LOAD, ee + 6, 32'd2, "R7");
        rd_at(A_LOAD, ee + 8, 32'd1, "R7");
        wr(A_STAT, 32'h1, ew);
        push_irq(ee + 12, 7);
        rd_at(A_LOAD, ee + 12, 32'd2, "R7");
        wr(A_CTRL, 32'h10, ew);
        rd_at(A_LOAD, ee + 14, 32'd1, "R4");
        rd_at(A_LOAD, ee + 30, 32'd1, "R4");
        wr(A_STAT, 32'h1, ew);

        // R6 free-running, reload 1: wrap to all ones
        wr(A_CTRL, 32'h00, ew);
        wr(A_LOAD, 32'd1, ew);
        wr(A_CTRL, 32'h80, ee);
        push_irq(ee + 4, 6);
        rd_at(A_LOAD, ee + 4, 32'hFFFF, "R6");
        rd_at(A_LOAD, ee + 6, 32'hFFFE, "R6");
        wr(A_CTRL, 32'h00, ew);
        wr(A_STAT, 32'h1, ew);

        // R3 divide by 8, and R5 reload restarting the divider mid-period
        wr(A_CTRL, 32'h22, ew);
        wr(A_LOAD, 32'd1, ew);
        wr(A_CTRL, 32'hA2, ee);
        rd_at(A_LOAD, ee + 7, 32'd1, "R3");
        rd_at(A_LOAD, ee + 8, 32'd0, "R3");
        wr(A_LOAD, 32'd1, el);
        rd_at(A_LOAD, el + 7, 32'd1, "R5");
        rd_at(A_LOAD, el + 8, 32'd0, "R5");
        push_irq(el + 16, 3);
        wait_neg(el + 18);
        wr(A_STAT, 32'h1, ew);
        wr(A_CTRL, 32'h22, ew);

        // R9 watchdog with a kick one clock before it would fire
        wr(A_CTRL, 32'h30, ew);
        wr(A_LOAD, 32'd3, ew);
        wr(A_CTRL, 32'hB0, ee);
        wait_neg(ee + 5);
        wr(A_LOAD, 32'd3, ek);
        push_rst(ek + 8);
        rd_at(A_LOAD, ek + 6, 32'd0, "R5");
        rd_at(A_STAT, ek + 9, 32'h2, "R9");
        chk("R9", {31'b0, rst_req}, 32'h0);
        wait_neg(ek + 30);

        // R10 cause flag survives the system reset, everything else clears
        pulse_sys_rst();
        @(negedge clk);
        rd_now(A_STAT, 32'h2, "R10");
        rd_now(A_CTRL, 32'h0, "R10");
        rd_now(A_LOAD, 32'h0, "R10");
        wr(A_STAT, 32'h2, ew);
        rd_at(A_STAT, ew, 32'h0, "R10");

        // R10 power-on reset clears the cause flag
        wr(A_CTRL, 32'h30, ew);
        wr(A_LOAD, 32'd0, ew);
        wr(A_CTRL, 32'hB0, ee);
        push_rst(ee + 2);
        rd_at(A_STAT, ee + 4, 32'h2, "R9");
        pulse_por();
        @(negedge clk);
        rd_now(A_STAT, 32'h0, "R10");

        repeat (10) @(negedge clk);
        checks++;
        if (irq_q.size() != 0 || rst_q.size() != 0) begin
            fails++;
            $display("FAIL R11 pending events actual=%0d expected=0", irq_q.size() + rst_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule